// File: doc/BRIEF.md
# Dual-Path Synthesizer Divider Configuration Loader

This block holds the divider settings of a frequency synthesizer: a 9-bit loop-divider value, a 2-bit output-divider code and a 3-bit test-select field. The settings arrive over one of two paths. A parallel path samples dedicated loop-divider and output-divider pins when an active-low load strobe returns high. A three-wire serial path shifts a 14-bit word in on rising edges of a serial clock and commits it when a serial load strobe falls. Both paths write the same configuration registers. The parallel path wins any conflict.

All strobes and the serial data pin come from outside the system clock domain. Each one passes through a two-flop synchronizer, and edges are detected from the synchronized levels. The block also turns the output-divider code into the division ratio it selects. Reset fills the configuration with all ones, which is the value an unconnected, pulled-up parallel bus would give. Reset also clears the shift register.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released with no load event, cfgM reads 511, cfgN reads 3, cfgT reads 7 and divRatio reads 16.
- R2: On a low-to-high transition of parLoadN, cfgM takes the value of parM and cfgN takes the value of parN. cfgT keeps its value.
- R3: A falling edge of parLoadN does not change the configuration. Holding parLoadN low does not change it either.
- R4: Each rising edge of serClk shifts serData into the shift register. The serial word is sent most significant bit first, in the order T[2:0], N[1:0], M[8:0], so the last bit sent is M[0]. Only the last 14 bits sent are kept.
- R5: On a high-to-low transition of serLoad, cfgT takes word bits 13:11, cfgN takes bits 10:9 and cfgM takes bits 8:0.
- R6: A rising edge of serLoad does not change the configuration.
- R7: A serial commit is ignored while the synchronized parLoadN is low.
- R8: When a parLoadN rising edge and a serLoad falling edge are detected in the same cycle, the parallel values are loaded and cfgT is unchanged.
- R9: divRatio follows cfgN as 0 to 2, 1 to 4, 2 to 8 and 3 to 16.
- R10: A change on a strobe pin reaches the configuration outputs on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| parLoadN | input | 1 | Active-low parallel load strobe; the parallel pins are captured when it rises |
| parM | input | 9 | Parallel loop-divider value |
| parN | input | 2 | Parallel output-divider code |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Serial commit strobe; the word is committed when it falls |
| cfgM | output | 9 | Loop-divider setting |
| cfgN | output | 2 | Output-divider code |
| cfgT | output | 3 | Test-select field |
| divRatio | output | 5 | Output division ratio chosen by cfgN |

## Verification
A fault in the synchronizer or the edge logic shows up at the configuration ports as wrong timing or a wrong trigger. A load can appear a cycle early or late against the three-edge latency, or a falling parallel strobe or a rising serial strobe can cause a load. A fault in the shift register, such as wrong bit order or a missed or doubled shift, is hidden until the next serial commit. At that commit it appears as a shuffled T, N or M field. Arbitration faults appear only in the conflict and blocking cases, as a committed serial word or a changed test field. The bench therefore checks each of these cases explicitly, sampling right after the expected edge.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  parameter int M_W = 9;
  parameter int N_W = 2;
  parameter int T_W = 3;
  parameter int SYNC_STAGES = 2;
  localparam int WORD_W = T_W + N_W + M_W;
  localparam int RATIO_W = (1 << N_W) + 1;

  typedef struct packed {
    logic parLevel;   // synchronized level of the parallel strobe
    logic parCommit;  // parallel capture this cycle
    logic serCommit;  // serial commit this cycle (already arbitrated)
    logic shiftEn;    // shift one serial bit this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_loader_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         parLoadN,
  input  logic         serClk,
  input  logic         serLoad,
  input  logic         serData,
  output ctrlStrobes_t strobes,
  output logic         serBit
);
  localparam int NUM_IN = 4;
  localparam logic [NUM_IN-1:0] RST_LEVELS = 4'b0001;  // parLoadN idles high

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic [NUM_IN-1:0] prevIn;

  assign rawIn = {serData, serLoad, serClk, parLoadN};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_LEVELS[i])) uSync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[i]),
      .q   (syncIn[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= RST_LEVELS;
    else       prevIn <= syncIn;
  end

  logic parRise, serClkRise, serLoadFall;
  assign parRise     = syncIn[0] & ~prevIn[0];
  assign serClkRise  = syncIn[1] & ~prevIn[1];
  assign serLoadFall = ~syncIn[2] & prevIn[2];

  always_comb begin
    strobes.parLevel  = syncIn[0];
    strobes.parCommit = parRise;
    strobes.serCommit = serLoadFall & syncIn[0] & ~parRise;
    strobes.shiftEn   = serClkRise;
  end

  assign serBit = syncIn[3];
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               serBit,
  input  logic [M_W-1:0]     parM,
  input  logic [N_W-1:0]     parN,
  output logic [M_W-1:0]     cfgM,
  output logic [N_W-1:0]     cfgN,
  output logic [T_W-1:0]     cfgT,
  output logic [RATIO_W-1:0] divRatio
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], serBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgM <= '1;
      cfgN <= '1;
      cfgT <= '1;
    end else if (strobes.parCommit) begin
      cfgM <= parM;
      cfgN <= parN;
    end else if (strobes.serCommit) begin
      cfgT <= shiftReg[WORD_W-1 -: T_W];
      cfgN <= shiftReg[M_W +: N_W];
      cfgM <= shiftReg[M_W-1:0];
    end
  end

  assign divRatio = RATIO_W'(2) << cfgN;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               parLoadN,
  input  logic [M_W-1:0]     parM,
  input  logic [N_W-1:0]     parN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLoad,
  output logic [M_W-1:0]     cfgM,
  output logic [N_W-1:0]     cfgN,
  output logic [T_W-1:0]     cfgT,
  output logic [RATIO_W-1:0] divRatio
);
  ctrlStrobes_t strobes;
  logic serBit;

  cfg_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .parLoadN(parLoadN),
    .serClk  (serClk),
    .serLoad (serLoad),
    .serData (serData),
    .strobes (strobes),
    .serBit  (serBit)
  );

  cfg_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .serBit  (serBit),
    .parM    (parM),
    .parN    (parN),
    .cfgM    (cfgM),
    .cfgN    (cfgN),
    .cfgT    (cfgT),
    .divRatio(divRatio)
  );
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [M_W-1:0]     parM,
  input logic [N_W-1:0]     parN,
  input logic [M_W-1:0]     cfgM,
  input logic [N_W-1:0]     cfgN,
  input logic [T_W-1:0]     cfgT,
  input logic [RATIO_W-1:0] divRatio,
  input ctrlStrobes_t       strobes
);
  // R1: reset forces the pulled-up defaults
  a_r1_reset_defaults: assert property (@(posedge clk)
    !rstN |=> (&cfgM) && (&cfgN) && (&cfgT));

  // R2: parallel capture loads the pins
  a_r2_par_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parCommit |=> (cfgM == $past(parM)) && (cfgN == $past(parN)) && $stable(cfgT));

  // R3: without a commit strobe the configuration holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.parCommit || strobes.serCommit) |=> $stable({cfgM, cfgN, cfgT}));

  // R7: no serial commit while the parallel strobe is low
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.parLevel |-> !strobes.serCommit);

  // R8: never two commits at once
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.parCommit, strobes.serCommit}));

  // R9: ratio is a power of two between 2 and 16
  a_r9_ratio_shape: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(divRatio) == 1) && !divRatio[0]);
endmodule

bind synth_cfg_loader synth_cfg_loader_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .parM    (parM),
  .parN    (parN),
  .cfgM    (cfgM),
  .cfgN    (cfgN),
  .cfgT    (cfgT),
  .divRatio(divRatio),
  .strobes (strobes)
);

// File: tb/tb_synth_cfg_loader.sv
module tb_synth_cfg_loader;
  logic clk = 0;
  logic rstN = 0;
  logic parLoadN = 0;
  logic [8:0] parM = '1;
  logic [1:0] parN = '1;
  logic serClk = 0, serData = 0, serLoad = 0;
  logic [8:0] cfgM;
  logic [1:0] cfgN;
  logic [2:0] cfgT;
  logic [4:0] divRatio;

  int tests = 0, failed = 0;
  int expM = 511, expN = 3, expT = 7;

  always #10 clk = ~clk;  // 50 MHz

  synth_cfg_loader dut (
    .clk(clk), .rstN(rstN), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT), .divRatio(divRatio)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkCfg(input string tag);
    check(tag, int'(cfgM), expM);
    check(tag, int'(cfgN), expN);
    check(tag, int'(cfgT), expT);
    check({tag, "/R9"}, int'(divRatio), 2 << expN);
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic parLoad(input int m, input int n);
    parM = 9'(m); parN = 2'(n); parLoadN = 0;
    waitNeg(4);
    parLoadN = 1;
    waitNeg(4);
    expM = m; expN = n;
  endtask

  task automatic shiftBits(input logic [14:0] bits, input int count);
    for (int i = count - 1; i >= 0; i--) begin
      serData = bits[i];
      waitNeg(3);
      serClk = 1;
      waitNeg(3);
      serClk = 0;
    end
    waitNeg(3);
  endtask

  task automatic serCommit();
    serLoad = 1; waitNeg(4);
    serLoad = 0; waitNeg(4);
  endtask

  function automatic logic [13:0] mkWord(input int t, input int n, input int m);
    return {3'(t), 2'(n), 9'(m)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    waitNeg(3);
    checkCfg("R1 in reset");
    rstN = 1;
    waitNeg(5);
    checkCfg("R1 after release");

    // R2 / R9: parallel sweep over every N code and spread of M values
    for (int n = 0; n < 4; n++)
      for (int k = 0; k < 6; k++) begin
        parLoad((k * 97 + n * 31) % 512, n);
        checkCfg("R2 parallel sweep");
      end
    parLoad(0, 0);   checkCfg("R2 M min");
    parLoad(511, 3); checkCfg("R2 M max");

    // R10: latency of exactly three edges
    parM = 9'd300; parN = 2'd1; parLoadN = 0;
    waitNeg(4);
    parLoadN = 1;
    waitNeg(2);
    check("R10 not before third edge", int'(cfgM), 511);
    waitNeg(1);
    check("R10 at third edge", int'(cfgM), 300);
    expM = 300; expN = 1;
    waitNeg(3);

    // R3: falling edge and held low leave config alone
    parM = 9'd5; parN = 2'd2; parLoadN = 0;
    waitNeg(8);
    checkCfg("R3 falling/low no capture");
    parLoadN = 1; waitNeg(4);
    expM = 5; expN = 2;
    checkCfg("R2 after low hold");

    // R4 / R5: serial sweep over all T and N codes
    for (int t = 0; t < 8; t++)
      for (int n = 0; n < 4; n++) begin
        int m = (t * 67 + n * 13 + 1) % 512;
        shiftBits({1'b0, mkWord(t, n, m)}, 14);
        serCommit();
        expT = t; expN = n; expM = m;
        checkCfg("R5 serial sweep");
      end

    // R4: only last 14 bits kept
    shiftBits({1'b1, mkWord(2, 1, 170)}, 15);
    serCommit();
    expT = 2; expN = 1; expM = 170;
    checkCfg("R4 extra leading bit dropped");

    // R6: rising serLoad alone does not commit
    shiftBits({1'b0, mkWord(6, 3, 77)}, 14);
    serLoad = 1; waitNeg(6);
    checkCfg("R6 rising edge ignored");
    serLoad = 0; waitNeg(4);
    expT = 6; expN = 3; expM = 77;
    checkCfg("R5 falling edge commits");

    // R7: serial commit while parallel strobe low is ignored
    parM = 9'd400; parN = 2'd0; parLoadN = 0;
    waitNeg(4);
    shiftBits({1'b0, mkWord(1, 2, 9)}, 14);
    serCommit();
    checkCfg("R7 serial blocked while low");
    parLoadN = 1; waitNeg(4);
    expM = 400; expN = 0;
    checkCfg("R7 parallel after block");

    // R8: simultaneous edges, parallel wins, T unchanged
    shiftBits({1'b0, mkWord(3, 1, 250)}, 14);
    parM = 9'd123; parN = 2'd2; parLoadN = 0;
    serLoad = 1;
    waitNeg(5);
    parLoadN = 1; serLoad = 0;
    waitNeg(5);
    expM = 123; expN = 2;
    checkCfg("R8 parallel wins conflict");

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule